// File: doc/BRIEF.md
# Device Director Function Controller

This block runs the control (director) commands that a processor sends to a small group of peripheral devices. It holds, for each device, an interrupt-enable register, a copy of that register's value from before the last enable request, and a status word whose low bit is the device's interrupt flag. A command is one strobe that carries a device select, a command word, a data word, a mask of the command bits the device supports and a mask of the bits that form the enable field. A command can clear interrupts, clear the controller, set interrupt enables, or do a combination of these.

Every cycle the block also rebuilds a global pending-interrupt word. Bit 0 follows the processor's own interrupt line. Each higher bit is the OR of the interrupt codes of the devices and of the buffered-channel interrupt lines. The parameter `STACK_OK` decides whether a clear and an enable request can share one command.

Top module: `dfc_top`

## Requirements
- R1: Command bits outside `supp_mask_i` are removed before decoding. A command with no supported bit changes no register and gives no pulse.
- R2: When the effective command has bit 1 (clear controller) set, `clr_ctl_o` gives a one-cycle pulse on the bit of the selected device. Bit 0 (clear interrupts) alone gives no pulse.
- R3: When the effective command has bit 0 or bit 1 set, the selected device's enable register and saved-enable register become zero. Its status bits that are set in `CLR_MASK` are also cleared; status bits outside `CLR_MASK` keep their value.
- R4: With `STACK_OK`=0, a clear in the effective command cancels every other bit of that command, and `en_chg_o` stays low.
- R5: With `STACK_OK`=1, the enable field of a command that also clears is applied after the clear, in the same cycle. The saved-enable register therefore becomes zero.
- R6: The enable field is `ien_mask_i` with bits 0 and 1 forced off. When any bit of the effective command falls in this field, the saved-enable register takes the old enable value and the enable register takes its old value ORed with `data_i` masked by the field. `en_chg_o` pulses high for one cycle. This path never clears an enable bit.
- R7: Devices that are not selected, and all devices on cycles without `cmd_vld_i`, keep their enable and saved-enable registers.
- R8: Device d raises interrupt code bit d+1 when its status bit 0 is set and its `zero_stat_i` bit is low.
- R9: `pend_o` is registered. Bit 0 equals `cpu_irq_i` from the previous cycle. Bit k≥1 is the OR of the device codes, taken from the status held in the previous cycle, and `chan_irq_i` bit k-1.
- R10: Each cycle, `stat_set_i` is ORed into every device's status. When a set and a clear hit the same status bit in the same cycle, the clear wins.
- R11: A synchronous active-high reset clears every enable, saved-enable and status register, every pulse output and `pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld_i | input | 1 | Command strobe |
| dev_sel_i | input | SEL_W | Selected device |
| cmd_i | input | CMD_W | Command word: bit 0 clears interrupts, bit 1 clears the controller, the enable field sits above |
| data_i | input | CMD_W | Data word that holds the enable bits |
| supp_mask_i | input | CMD_W | Command bits the device supports |
| ien_mask_i | input | CMD_W | Bits that form the enable field |
| stat_set_i | input | NUM_DEV*STAT_W | Status bits each device raises this cycle |
| zero_stat_i | input | NUM_DEV | Device reports zero status (interrupt code suppressed) |
| cpu_irq_i | input | 1 | Processor interrupt, carried to pending bit 0 |
| chan_irq_i | input | PEND_W-1 | Buffered-channel interrupt codes for pending bits 1 and up |
| en_o | output | NUM_DEV*CMD_W | Interrupt-enable registers |
| prev_en_o | output | NUM_DEV*CMD_W | Saved-enable registers |
| stat_o | output | NUM_DEV*STAT_W | Device status words |
| clr_ctl_o | output | NUM_DEV | Clear-controller pulse, one per device |
| en_chg_o | output | 1 | Enable register changed by the last command |
| pend_o | output | PEND_W | Global pending-interrupt word |

## Verification
A wrong decode shows on `en_o`, `prev_en_o`, `stat_o`, `clr_ctl_o` and `en_chg_o` at the edge right after the strobe, because all of these are registered once. A status error first shows on `stat_o` and then, one cycle later, in `pend_o`. If the stacking rule is wrong, the two configurations diverge: with stacking allowed, clear-plus-enable commands leave a nonzero enable; with stacking not allowed, they leave zero. Driving both configurations with the same stimulus exposes this at once.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int CLR_INT_BIT  = 0;
    localparam int CLR_CTL_BIT  = 1;
    localparam int INT_STAT_BIT = 0;

    typedef struct packed {
        logic clr_any;
        logic clr_ctl;
        logic en_req;
    } dir_req_t;

endpackage

// File: rtl/dfc_decode.sv
module dfc_decode
    import dfc_pkg::*;
#(
    parameter int CMD_W    = 8,
    parameter bit STACK_OK = 1'b1
) (
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [CMD_W-1:0] supp_mask_i,
    input  logic [CMD_W-1:0] ien_mask_i,
    input  logic [CMD_W-1:0] data_i,
    output dir_req_t         req_o,
    output logic [CMD_W-1:0] en_add_o
);
    localparam logic [CMD_W-1:0] CLR_BITS = CMD_W'(3);

    logic [CMD_W-1:0] eff;
    logic [CMD_W-1:0] field;
    logic             field_hit;

    assign eff       = cmd_i & supp_mask_i;
    assign field     = ien_mask_i & ~CLR_BITS;
    assign field_hit = |(eff & field);
    assign en_add_o  = data_i & field;

    assign req_o.clr_any = eff[CLR_INT_BIT] | eff[CLR_CTL_BIT];
    assign req_o.clr_ctl = eff[CLR_CTL_BIT];

    generate
        if (STACK_OK) begin : g_stack
            assign req_o.en_req = field_hit;
        end else begin : g_nostack
            assign req_o.en_req = field_hit & ~(eff[CLR_INT_BIT] | eff[CLR_CTL_BIT]);
        end
    endgenerate
endmodule

// File: rtl/dfc_dev_slot.sv
module dfc_dev_slot
    import dfc_pkg::*;
#(
    parameter int               CMD_W    = 8,
    parameter int               STAT_W   = 4,
    parameter logic [STAT_W-1:0] CLR_MASK = 4'b0111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  dir_req_t          req_i,
    input  logic [CMD_W-1:0]  en_add_i,
    input  logic [STAT_W-1:0] stat_set_i,
    input  logic              zero_stat_i,
    output logic [CMD_W-1:0]  en_o,
    output logic [CMD_W-1:0]  prev_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              clr_ctl_o,
    output logic              irq_o
);
    logic [CMD_W-1:0]  en_q, prev_q, en_nxt, prev_nxt, en_base, prev_base;
    logic [STAT_W-1:0] stat_q, stat_drop;
    logic              clr_ctl_q;
    logic              do_clr;

    assign do_clr    = hit_i & req_i.clr_any;
    assign stat_drop = do_clr ? CLR_MASK : '0;

    always_comb begin
        en_base   = do_clr ? '0 : en_q;
        prev_base = do_clr ? '0 : prev_q;
        if (hit_i && req_i.en_req) begin
            prev_nxt = en_base;
            en_nxt   = en_base | en_add_i;
        end else begin
            prev_nxt = prev_base;
            en_nxt   = en_base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            prev_q    <= '0;
            stat_q    <= '0;
            clr_ctl_q <= 1'b0;
        end else begin
            en_q      <= en_nxt;
            prev_q    <= prev_nxt;
            stat_q    <= (stat_q | stat_set_i) & ~stat_drop;
            clr_ctl_q <= hit_i & req_i.clr_ctl;
        end
    end

    assign en_o      = en_q;
    assign prev_o    = prev_q;
    assign stat_o    = stat_q;
    assign clr_ctl_o = clr_ctl_q;
    assign irq_o     = stat_q[INT_STAT_BIT] & ~zero_stat_i;
endmodule

// File: rtl/dfc_pend.sv
module dfc_pend #(
    parameter int NUM_DEV = 4,
    parameter int PEND_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_DEV-1:0] dev_irq_i,
    input  logic [PEND_W-1:1] chan_irq_i,
    input  logic              cpu_irq_i,
    output logic [PEND_W-1:0] pend_o
);
    logic [PEND_W-1:1] agg;
    logic [PEND_W-1:0] pend_q;

    always_comb begin
        agg = chan_irq_i;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (dev_irq_i[d]) agg[d+1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= {agg, cpu_irq_i};
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/dfc_top.sv
module dfc_top
    import dfc_pkg::*;
#(
    parameter int                NUM_DEV  = 4,
    parameter int                CMD_W    = 8,
    parameter int                STAT_W   = 4,
    parameter int                PEND_W   = 8,
    parameter logic [STAT_W-1:0] CLR_MASK = 4'b0111,
    parameter bit                STACK_OK = 1'b1,
    localparam int               SEL_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_vld_i,
    input  logic [SEL_W-1:0]          dev_sel_i,
    input  logic [CMD_W-1:0]          cmd_i,
    input  logic [CMD_W-1:0]          data_i,
    input  logic [CMD_W-1:0]          supp_mask_i,
    input  logic [CMD_W-1:0]          ien_mask_i,
    input  logic [NUM_DEV*STAT_W-1:0] stat_set_i,
    input  logic [NUM_DEV-1:0]        zero_stat_i,
    input  logic                      cpu_irq_i,
    input  logic [PEND_W-2:0]         chan_irq_i,
    output logic [NUM_DEV*CMD_W-1:0]  en_o,
    output logic [NUM_DEV*CMD_W-1:0]  prev_en_o,
    output logic [NUM_DEV*STAT_W-1:0] stat_o,
    output logic [NUM_DEV-1:0]        clr_ctl_o,
    output logic                      en_chg_o,
    output logic [PEND_W-1:0]         pend_o
);
    dir_req_t          req;
    logic [CMD_W-1:0]  en_add;
    logic [NUM_DEV-1:0] dev_irq;
    logic              en_chg_q;

    dfc_decode #(.CMD_W(CMD_W), .STACK_OK(STACK_OK)) u_dec (
        .cmd_i      (cmd_i),
        .supp_mask_i(supp_mask_i),
        .ien_mask_i (ien_mask_i),
        .data_i     (data_i),
        .req_o      (req),
        .en_add_o   (en_add)
    );

    generate
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_slot
            logic hit;
            assign hit = cmd_vld_i && (dev_sel_i == SEL_W'(d));
            dfc_dev_slot #(.CMD_W(CMD_W), .STAT_W(STAT_W), .CLR_MASK(CLR_MASK)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .hit_i      (hit),
                .req_i      (req),
                .en_add_i   (en_add),
                .stat_set_i (stat_set_i[d*STAT_W +: STAT_W]),
                .zero_stat_i(zero_stat_i[d]),
                .en_o       (en_o[d*CMD_W +: CMD_W]),
                .prev_o     (prev_en_o[d*CMD_W +: CMD_W]),
                .stat_o     (stat_o[d*STAT_W +: STAT_W]),
                .clr_ctl_o  (clr_ctl_o[d]),
                .irq_o      (dev_irq[d])
            );
        end
    endgenerate

    dfc_pend #(.NUM_DEV(NUM_DEV), .PEND_W(PEND_W)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .dev_irq_i (dev_irq),
        .chan_irq_i(chan_irq_i),
        .cpu_irq_i (cpu_irq_i),
        .pend_o    (pend_o)
    );

    always_ff @(posedge clk) begin
        if (rst) en_chg_q <= 1'b0;
        else     en_chg_q <= cmd_vld_i & req.en_req;
    end

    assign en_chg_o = en_chg_q;
endmodule

// File: rtl/dfc_chk.sv
module dfc_chk #(
    parameter int NUM_DEV  = 4,
    parameter int CMD_W    = 8,
    parameter int PEND_W   = 8,
    parameter bit STACK_OK = 1'b1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_vld_i,
    input logic [CMD_W-1:0]         cmd_i,
    input logic [CMD_W-1:0]         supp_mask_i,
    input logic                     cpu_irq_i,
    input logic [NUM_DEV*CMD_W-1:0] en_o,
    input logic [NUM_DEV*CMD_W-1:0] prev_en_o,
    input logic [NUM_DEV-1:0]       clr_ctl_o,
    input logic                     en_chg_o,
    input logic [PEND_W-1:0]        pend_o
);
    logic [CMD_W-1:0] eff;
    assign eff = cmd_i & supp_mask_i;

    p_unsupp_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld_i && eff == '0) |=> (!en_chg_o && clr_ctl_o == '0 && $stable(en_o) && $stable(prev_en_o)));

    p_clr_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_ctl_o));

    p_clr_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld_i && eff[1]) |=> (clr_ctl_o != '0));

    p_clr_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_vld_i && eff[1]) |=> (clr_ctl_o == '0));

    p_nostack_r4: assert property (@(posedge clk) disable iff (rst)
        (!STACK_OK && cmd_vld_i && (eff[0] || eff[1])) |=> !en_chg_o);

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_vld_i |=> ($stable(en_o) && $stable(prev_en_o) && !en_chg_o));

    p_grow_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld_i && !eff[0] && !eff[1]) |=> ((en_o & $past(en_o)) == $past(en_o)));

    p_cpu_bit_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_o[0] == $past(cpu_irq_i)));
endmodule

bind dfc_top dfc_chk #(
    .NUM_DEV (NUM_DEV),
    .CMD_W   (CMD_W),
    .PEND_W  (PEND_W),
    .STACK_OK(STACK_OK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_vld_i  (cmd_vld_i),
    .cmd_i      (cmd_i),
    .supp_mask_i(supp_mask_i),
    .cpu_irq_i  (cpu_irq_i),
    .en_o       (en_o),
    .prev_en_o  (prev_en_o),
    .clr_ctl_o  (clr_ctl_o),
    .en_chg_o   (en_chg_o),
    .pend_o     (pend_o)
);

// File: tb/tb_dfc_top.sv
module tb_dfc_top;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;
    localparam int CW = 8;
    localparam int SW = 4;
    localparam int PW = 8;
    localparam logic [SW-1:0] CLRM = 4'b0111;
    localparam int ITER = 2048;

    logic clk = 1'b0;
    logic rst;
    logic cmd_vld;
    logic [1:0] dev_sel;
    logic [CW-1:0] cmd, data, supp, ienm;
    logic [ND*SW-1:0] sset;
    logic [ND-1:0] zst;
    logic cpu_irq;
    logic [PW-2:0] chan;

    logic [ND*CW-1:0] en_a, pr_a, en_b, pr_b;
    logic [ND*SW-1:0] st_a, st_b;
    logic [ND-1:0] cc_a, cc_b;
    logic chg_a, chg_b;
    logic [PW-1:0] pd_a, pd_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dfc_top #(.STACK_OK(1'b1)) dut (
        .clk(clk), .rst(rst), .cmd_vld_i(cmd_vld), .dev_sel_i(dev_sel), .cmd_i(cmd),
        .data_i(data), .supp_mask_i(supp), .ien_mask_i(ienm), .stat_set_i(sset),
        .zero_stat_i(zst), .cpu_irq_i(cpu_irq), .chan_irq_i(chan),
        .en_o(en_a), .prev_en_o(pr_a), .stat_o(st_a), .clr_ctl_o(cc_a),
        .en_chg_o(chg_a), .pend_o(pd_a));

    dfc_top #(.STACK_OK(1'b0)) dut_ns (
        .clk(clk), .rst(rst), .cmd_vld_i(cmd_vld), .dev_sel_i(dev_sel), .cmd_i(cmd),
        .data_i(data), .supp_mask_i(supp), .ien_mask_i(ienm), .stat_set_i(sset),
        .zero_stat_i(zst), .cpu_irq_i(cpu_irq), .chan_irq_i(chan),
        .en_o(en_b), .prev_en_o(pr_b), .stat_o(st_b), .clr_ctl_o(cc_b),
        .en_chg_o(chg_b), .pend_o(pd_b));

    // bench model, index 0: stacking allowed, index 1: not allowed
    logic [CW-1:0] m_en [2][ND];
    logic [CW-1:0] m_pr [2][ND];
    logic [SW-1:0] m_st [2][ND];
    logic [ND-1:0] m_cc [2];
    logic          m_chg [2];
    logic [PW-1:0] m_pd [2];
    logic [15:0]   lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] adv(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    task automatic model_step();
        logic [CW-1:0] eff, fld, ebase;
        logic clr, hitf;
        eff  = cmd & supp;
        fld  = ienm & ~CW'(3);
        clr  = eff[0] | eff[1];
        hitf = |(eff & fld);
        for (int s = 0; s < 2; s++) begin
            // R9 / R8: pending built from status held before this edge
            logic [PW-1:0] p;
            p = {chan, cpu_irq};
            for (int d = 0; d < ND; d++)
                if (m_st[s][d][0] && !zst[d]) p[d+1] = 1'b1;
            m_pd[s] = p;
            m_cc[s] = '0;
            m_chg[s] = 1'b0;
            for (int d = 0; d < ND; d++) begin
                logic h;
                h = cmd_vld && (dev_sel == 2'(d));
                // R10: set then clear, clear wins
                m_st[s][d] = (m_st[s][d] | sset[d*SW +: SW]) & ~((h && clr) ? CLRM : '0);
                if (h) begin
                    m_cc[s][d] = eff[1];
                    if (clr) begin
                        m_en[s][d] = '0;
                        m_pr[s][d] = '0;
                    end
                    if (hitf && (s == 0 || !clr)) begin
                        ebase = m_en[s][d];
                        m_pr[s][d] = ebase;
                        m_en[s][d] = ebase | (data & fld);
                        m_chg[s] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic compare();
        logic [ND*CW-1:0] xe [2];
        logic [ND*CW-1:0] xp [2];
        logic [ND*SW-1:0] xs [2];
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < ND; d++) begin
                xe[s][d*CW +: CW] = m_en[s][d];
                xp[s][d*CW +: CW] = m_pr[s][d];
                xs[s][d*SW +: SW] = m_st[s][d];
            end
        chk(en_a == xe[0], "R1/R3/R5/R6/R7 en stack", 64'(en_a), 64'(xe[0]));
        chk(pr_a == xp[0], "R3/R5/R6 prev stack", 64'(pr_a), 64'(xp[0]));
        chk(st_a == xs[0], "R3/R10 status stack", 64'(st_a), 64'(xs[0]));
        chk(cc_a == m_cc[0], "R2 clear pulse stack", 64'(cc_a), 64'(m_cc[0]));
        chk(chg_a == m_chg[0], "R5/R6 en_chg stack", 64'(chg_a), 64'(m_chg[0]));
        chk(pd_a == m_pd[0], "R8/R9 pending stack", 64'(pd_a), 64'(m_pd[0]));
        chk(en_b == xe[1], "R4/R6/R7 en nostack", 64'(en_b), 64'(xe[1]));
        chk(pr_b == xp[1], "R4 prev nostack", 64'(pr_b), 64'(xp[1]));
        chk(st_b == xs[1], "R3/R10 status nostack", 64'(st_b), 64'(xs[1]));
        chk(cc_b == m_cc[1], "R2 clear pulse nostack", 64'(cc_b), 64'(m_cc[1]));
        chk(chg_b == m_chg[1], "R4 en_chg nostack", 64'(chg_b), 64'(m_chg[1]));
        chk(pd_b == m_pd[1], "R8/R9 pending nostack", 64'(pd_b), 64'(m_pd[1]));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_vld = 1'b0; dev_sel = '0; cmd = '0; data = '0;
        supp = '0; ienm = '0; sset = '0; zst = '0; cpu_irq = 1'b0; chan = '0;
        for (int s = 0; s < 2; s++) begin
            m_cc[s] = '0; m_chg[s] = 1'b0; m_pd[s] = '0;
            for (int d = 0; d < ND; d++) begin
                m_en[s][d] = '0; m_pr[s][d] = '0; m_st[s][d] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        compare();
        for (int i = 0; i < ITER; i++) begin
            lfsr = adv(lfsr);
            cmd_vld = (i % 7) != 3;
            dev_sel = 2'(i);
            cmd     = CW'(i >> 2);
            data    = lfsr[7:0];
            if (i < ITER/2) begin
                supp = '1;
                ienm = 8'hFC;
            end else begin
                supp = lfsr[15:8] | 8'h03;
                if (i % 5 == 0) supp = 8'h00;   // R1: nothing supported
                ienm = {lfsr[11:4]};
            end
            lfsr = adv(lfsr);
            sset    = (i % 3 == 0) ? (lfsr & {lfsr[7:0], lfsr[15:8]}) : '0;
            zst     = lfsr[3:0] & lfsr[7:4];
            cpu_irq = lfsr[9];
            chan    = lfsr[14:8] & lfsr[6:0] & {7{lfsr[15]}};
            model_step();
            @(negedge clk);
            compare();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule